// File: doc/BRIEF.md
# Power-Fail Protected Byte Memory

A synchronous model of an 8192-byte static memory with an active-low control interface in the usual byte-wide memory style: chip enable, output enable and write enable select deselect, read, write and output-disabled behaviour. A three-state data bus is represented by a registered read-data word plus a drive flag. A separate valid flag marks when the driven byte is defined.

A digital supply code (unsigned, 10 mV per step) replaces the analog supply measurement. Two thresholds gate all access. Below the deselect threshold the block ignores every control input, releases the bus and locks out writes. Below the lower switchover threshold it reports a retention-only backup state. The array contents survive both states and are readable again once the supply recovers. A build parameter picks one of two deselect thresholds, one for each supported supply range.

Reads take a configurable number of clock cycles. When the address moves during a read, the previous byte stays valid for a short hold window and is then undefined until the new access completes. A write is committed when the write strobe or the chip enable ends it, whichever comes first. A write that is still open when a power failure is detected is dropped.

Top module: `pfsram_core`

## Requirements
- R1: The array holds 2^13 = 8192 bytes addressed by `addr_i`. Address 0 and address 8191 store and return independent bytes.
- R2: With `ce_n_i` high and the supply good, `mode_o` is 0 (deselect), whatever the other controls are, and `drive_o` and `valid_o` are low.
- R3: With `ce_n_i` and `we_n_i` both low and the supply good, `mode_o` is 2 and `drive_o` is low, whatever `oe_n_i` is. The byte and address sampled at the last clock edge of that write are stored at the edge where `we_n_i` or `ce_n_i` is first seen high.
- R4: With `ce_n_i` and `oe_n_i` low, `we_n_i` high and the supply good, `mode_o` is 1 and `drive_o` is high. `valid_o` stays low for the first READ_LAT-1 edges of the access. After edge READ_LAT (default 3) it goes high, with the addressed byte on `rdata_o`.
- R5: With `ce_n_i` low and both `oe_n_i` and `we_n_i` high, `mode_o` is 3 (output disabled) and `drive_o` is low.
- R6: One edge after `supply_i` is sampled below the deselect threshold, `mode_o` is 4, `drive_o` and `valid_o` are low, and any write attempted in that state leaves the array unchanged. The same state holds during reset.
- R7: If the supply drops below the deselect threshold while a write is open, that write is dropped and the stored byte keeps its old value.
- R8: One edge after `supply_i` is sampled below SWITCH_THR (default 300), `mode_o` is 5 and the bus is released. A supply equal to SWITCH_THR gives 4, not 5. Contents written before the backup state read back unchanged after the supply returns.
- R9: The deselect threshold is 462 (4.62 V) when LOW_RANGE is 0 and 437 (4.37 V) when LOW_RANGE is 1. A supply equal to the threshold counts as good, and one step below it counts as failed.
- R10: If `addr_i` changes during a completed read, `valid_o` stays high with the old byte for HOLD_CYC (default 1) edges. It is then low until READ_LAT edges after the change, when the new byte appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_i | input | 10 | Supply code, 10 mV per step |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| drive_o | output | 1 | High when the data bus would be driven |
| valid_o | output | 1 | High when rdata_o is defined |
| mode_o | output | 3 | Mode: 0 deselect, 1 read, 2 write, 3 output disabled, 4 power-fail, 5 backup |

## Verification
The assertions assume that all control, address and data inputs are synchronous to `clk_i` and hold steady between rising edges. They also assume that SWITCH_THR is below both deselect thresholds and that HOLD_CYC is less than READ_LAT, so backup always implies power-fail and the hold window ends before the new data arrives. The bench changes every input only at the falling edge. It keeps the thresholds at their defaults, and it moves the supply across a threshold only while the controls are either idle or in a deliberately open write.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;
  typedef enum logic [2:0] {
    MODE_DESEL  = 3'd0,
    MODE_READ   = 3'd1,
    MODE_WRITE  = 3'd2,
    MODE_OUTDIS = 3'd3,
    MODE_PFAIL  = 3'd4,
    MODE_BACKUP = 3'd5
  } mode_e;
endpackage

// File: rtl/pfsram_supply_mon.sv
module pfsram_supply_mon #(
  parameter int SUPPLY_W   = 10,
  parameter bit LOW_RANGE  = 1'b0,
  parameter int DESEL_STD  = 462,
  parameter int DESEL_LOW  = 437,
  parameter int SWITCH_THR = 300
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SUPPLY_W-1:0] supply_i,
  output logic                pfail_o,
  output logic                backup_o
);
  logic [SUPPLY_W-1:0] desel_thr;
  logic pfail_q, backup_q;

  generate
    if (LOW_RANGE) begin : g_low_range
      assign desel_thr = SUPPLY_W'(DESEL_LOW);
    end else begin : g_std_range
      assign desel_thr = SUPPLY_W'(DESEL_STD);
    end
  endgenerate

  // reset comes up deselected until the first supply sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfail_q  <= 1'b1;
      backup_q <= 1'b0;
    end else begin
      pfail_q  <= supply_i < desel_thr;
      backup_q <= supply_i < SUPPLY_W'(SWITCH_THR);
    end
  end

  assign pfail_o  = pfail_q;
  assign backup_o = backup_q;

  // R8: backup is a deeper state than power-fail
  a_r8_backup_within_pfail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_o |-> pfail_o);
endmodule

// File: rtl/pfsram_ctrl.sv
module pfsram_ctrl
  import pfsram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pfail_i,
  input  logic              backup_i,
  output mode_e             mode_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  mode_e mode;
  logic pend_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    if (backup_i)     mode = MODE_BACKUP;
    else if (pfail_i) mode = MODE_PFAIL;
    else if (ce_n_i)  mode = MODE_DESEL;
    else if (!we_n_i) mode = MODE_WRITE;
    else if (!oe_n_i) mode = MODE_READ;
    else              mode = MODE_OUTDIS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (mode == MODE_WRITE) begin
      pend_q  <= 1'b1;
      waddr_q <= addr_i;
      wdata_q <= wdata_i;
    end else begin
      pend_q  <= 1'b0;
    end
  end

  // commit on the first edge after the strobe ends; power-fail drops it
  assign mem_we_o    = pend_q && (mode != MODE_WRITE) && !pfail_i;
  assign mem_waddr_o = waddr_q;
  assign mem_wdata_o = wdata_q;
  assign mode_o      = mode;

  // R3: a commit only follows a cycle spent in write mode
  a_r3_commit_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mode == MODE_WRITE));
  // R7: an open write seen under power-fail is discarded
  a_r7_abort_on_pfail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && pfail_i) |=> !pend_q);
endmodule

// File: rtl/pfsram_store.sv
module pfsram_store #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int READ_LAT = 3,
  parameter int HOLD_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(READ_LAT + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              rd_q, valid_q;
  logic [ADDR_W-1:0] acc_q, acc_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [HOLD_W-1:0] hold_q;
  logic [DATA_W-1:0] rdata_q, rd_word;
  logic              new_acc, done;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_comb begin
    new_acc = rd_i && (!rd_q || (addr_i != acc_q));
    acc_nxt = new_acc ? addr_i : acc_q;
    if (new_acc)                         cnt_nxt = CNT_W'(1);
    else if (cnt_q == CNT_W'(READ_LAT))  cnt_nxt = cnt_q;
    else                                 cnt_nxt = cnt_q + CNT_W'(1);
    done    = rd_i && (cnt_nxt == CNT_W'(READ_LAT)) && (new_acc || (cnt_q != CNT_W'(READ_LAT)));
    // forward a commit landing on the same edge as the fetch
    rd_word = (we_i && (waddr_i == acc_nxt)) ? wdata_i : mem[acc_nxt];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      valid_q <= 1'b0;
      acc_q   <= '0;
      cnt_q   <= '0;
      hold_q  <= '0;
      rdata_q <= '0;
    end else if (!rd_i) begin
      rd_q    <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      rd_q  <= 1'b1;
      acc_q <= acc_nxt;
      cnt_q <= cnt_nxt;
      if (done) begin
        rdata_q <= rd_word;
        valid_q <= 1'b1;
        hold_q  <= '0;
      end else if (new_acc) begin
        if (HOLD_CYC > 0 && rd_q && valid_q && hold_q == '0) begin
          hold_q  <= HOLD_W'(HOLD_CYC);
          valid_q <= 1'b1;
        end else begin
          hold_q  <= '0;
          valid_q <= 1'b0;
        end
      end else if (hold_q != '0) begin
        hold_q  <= hold_q - HOLD_W'(1);
        valid_q <= hold_q > HOLD_W'(1);
      end
    end
  end

  assign rdata_o = rdata_q;
  assign valid_o = valid_q && rd_i;

  // R10: old byte is kept unchanged during the hold window
  a_r10_hold_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0) |-> $stable(rdata_q));
  // R4: data only becomes valid out of a read access
  a_r4_valid_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(rd_i));
endmodule

// File: rtl/pfsram_core.sv
module pfsram_core
  import pfsram_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int SUPPLY_W   = 10,
  parameter bit LOW_RANGE  = 1'b0,
  parameter int DESEL_STD  = 462,
  parameter int DESEL_LOW  = 437,
  parameter int SWITCH_THR = 300,
  parameter int READ_LAT   = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SUPPLY_W-1:0] supply_i,
  input  logic                ce_n_i,
  input  logic                oe_n_i,
  input  logic                we_n_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                drive_o,
  output logic                valid_o,
  output logic [2:0]          mode_o
);
  logic pfail, backup, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  mode_e mode;

  pfsram_supply_mon #(
    .SUPPLY_W(SUPPLY_W), .LOW_RANGE(LOW_RANGE), .DESEL_STD(DESEL_STD),
    .DESEL_LOW(DESEL_LOW), .SWITCH_THR(SWITCH_THR)
  ) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_i(supply_i),
    .pfail_o(pfail), .backup_o(backup)
  );

  pfsram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .pfail_i(pfail), .backup_i(backup),
    .mode_o(mode), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  pfsram_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(READ_LAT), .HOLD_CYC(HOLD_CYC)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .rd_i(mode == MODE_READ), .addr_i(addr_i), .rdata_o(rdata_o), .valid_o(valid_o)
  );

  assign drive_o = (mode == MODE_READ);
  assign mode_o  = mode;

  // R6: a failed supply leaves the bus quiet and the array untouched
  a_r6_quiet_in_pfail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail |-> (!drive_o && !valid_o && !mem_we));
endmodule

// File: tb/pfsram_core_test.sv
module pfsram_core_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] supply = 10'd500;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, rdata_lo;
  logic        drive, valid, drive_lo, valid_lo;
  logic [2:0]  mode, mode_lo;
  int n_chk = 0;
  int n_bad = 0;

  localparam int LAT = 3;

  always #4 clk = ~clk;

  pfsram_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_i(supply), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .we_n_i(we_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive),
    .valid_o(valid), .mode_o(mode)
  );

  pfsram_core #(.LOW_RANGE(1'b1)) uut_lo (
    .clk_i(clk), .rst_ni(rst_ni), .supply_i(supply), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .we_n_i(we_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_lo), .drive_o(drive_lo),
    .valid_o(valid_lo), .mode_o(mode_lo)
  );

  // {supply, ce_n, oe_n, we_n, mode std, drive std, mode low-range}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {10'd500, 3'b100, 3'd0, 1'b0, 3'd0},
    {10'd500, 3'b111, 3'd0, 1'b0, 3'd0},
    {10'd500, 3'b011, 3'd3, 1'b0, 3'd3},
    {10'd500, 3'b001, 3'd1, 1'b1, 3'd1},
    {10'd500, 3'b010, 3'd2, 1'b0, 3'd2},
    {10'd500, 3'b000, 3'd2, 1'b0, 3'd2},
    {10'd462, 3'b001, 3'd1, 1'b1, 3'd1},
    {10'd461, 3'b001, 3'd4, 1'b0, 3'd1},
    {10'd437, 3'b001, 3'd4, 1'b0, 3'd1},
    {10'd436, 3'b001, 3'd4, 1'b0, 3'd4},
    {10'd300, 3'b001, 3'd4, 1'b0, 3'd4},
    {10'd299, 3'b111, 3'd5, 1'b0, 3'd5},
    {10'd500, 3'b000, 3'd2, 1'b0, 3'd2}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edge_sample(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input string req, input logic [12:0] a, input int exp);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    edge_sample(LAT);
    chk(req, "read valid", int'(valid), 1);
    chk(req, "read data", int'(rdata), exp);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R6: reset state
    edge_sample(2);
    chk("R6", "reset mode", int'(mode), 4);
    chk("R6", "reset drive", int'(drive), 0);
    chk("R6", "reset valid", int'(valid), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    edge_sample(1);
    chk("R2", "idle mode", int'(mode), 0);

    // R2 R3 R4 R5 R6 R8 R9: mode table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      supply = VEC[i][19:10];
      ce_n = VEC[i][9]; oe_n = VEC[i][8]; we_n = VEC[i][7];
      addr = 13'd7; wdata = 8'h77;
      edge_sample(1);
      chk("R2-R9 table", $sformatf("row %0d mode", i), int'(mode), int'(VEC[i][6:4]));
      chk("R2-R9 table", $sformatf("row %0d drive", i), int'(drive), int'(VEC[i][3]));
      chk("R9", $sformatf("row %0d low-range mode", i), int'(mode_lo), int'(VEC[i][2:0]));
    end
    idle();
    supply = 10'd500;
    edge_sample(1);

    // R1: both ends of the address space
    wr(13'd0, 8'hA1);
    wr(13'd8191, 8'h5E);
    rd("R1", 13'd0, 8'hA1);
    rd("R1", 13'd8191, 8'h5E);

    // R4: latency boundary
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 13'd0;
    edge_sample(LAT - 1);
    chk("R4", "valid before latency", int'(valid), 0);
    chk("R4", "drive during latency", int'(drive), 1);
    edge_sample(1);
    chk("R4", "valid at latency", int'(valid), 1);
    chk("R4", "data at latency", int'(rdata), 8'hA1);

    // R10: address change during read
    @(negedge clk);
    addr = 13'd8191;
    edge_sample(1);
    chk("R10", "hold valid", int'(valid), 1);
    chk("R10", "hold data old", int'(rdata), 8'hA1);
    edge_sample(1);
    chk("R10", "undefined window", int'(valid), 0);
    edge_sample(1);
    chk("R10", "new valid", int'(valid), 1);
    chk("R10", "new data", int'(rdata), 8'h5E);
    idle();

    // R3: write ended by chip enable, last data wins
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 13'd100; wdata = 8'h11;
    edge_sample(1);
    chk("R3", "write mode with oe low", int'(mode), 2);
    chk("R3", "write drive", int'(drive), 0);
    @(negedge clk);
    wdata = 8'h22;
    @(negedge clk);
    ce_n = 1'b1;
    rd("R3", 13'd100, 8'h22);

    // R7: power-fail during open write
    wr(13'd40, 8'h5A);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = 13'd40; wdata = 8'hA5;
    @(negedge clk);
    supply = 10'd400;
    edge_sample(1);
    chk("R7", "mode after drop", int'(mode), 4);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; supply = 10'd500;
    edge_sample(2);
    rd("R7", 13'd40, 8'h5A);

    // R6: full write attempt under power-fail
    @(negedge clk);
    supply = 10'd400;
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = 13'd40; wdata = 8'h33;
    edge_sample(1);
    chk("R6", "write ignored mode", int'(mode), 4);
    @(negedge clk);
    we_n = 1'b1; oe_n = 1'b0;
    edge_sample(1);
    chk("R6", "read ignored drive", int'(drive), 0);
    chk("R6", "read ignored valid", int'(valid), 0);
    idle();
    supply = 10'd500;
    edge_sample(1);
    rd("R6", 13'd40, 8'h5A);

    // R8: backup retains contents
    @(negedge clk);
    supply = 10'd250;
    edge_sample(1);
    chk("R8", "backup mode", int'(mode), 5);
    chk("R8", "backup drive", int'(drive), 0);
    edge_sample(5);
    @(negedge clk);
    supply = 10'd500;
    edge_sample(1);
    chk("R8", "recovered mode", int'(mode), 0);
    rd("R8", 13'd8191, 8'h5E);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule